// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the software-visible register file of a serial port. A bus master issues 16-bit reads and writes at word-spaced offsets. The block holds the baud divisor halves, global, line and modem control, a scratch word, the interrupt-enable mask, the transmit holding byte and the last received byte. It also keeps sticky line and modem status flags. The shifter, baud generator and FIFOs sit outside. They connect through level status inputs, event inputs that set the sticky flags, and one-cycle strobes for loading a transmit byte, popping a receive byte and raising a transmit event.

Each request is taken in one cycle. A response appears on the next cycle, with read data and two error flags. The mask is changed only through a set port and a clear port. Error flags are cleared by writing ones. A read of line status merges the live receiver-ready, holding-empty and transmitter-idle levels into the stored sticky bits.

Top module: `uart_regbank`

## Requirements
- R1: After reset the low divisor reads 0x0001 and the high divisor, global, line and modem control, scratch, mask, transmit byte and sticky flags are all zero. A line-status read with rx_ready=0, tx_hold_empty=1 and tx_idle=1 returns 0x0060.
- R2: A request with req_size other than 2'b01 (the only legal size, 16 bits) raises rsp_err_size and changes nothing. It never raises rsp_err_map, even when the offset is also bad.
- R3: Register index is req_addr>>2: 0 low divisor, 1 high divisor, 2 global control, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 mask-set, 9 mask-clear, 10 transmit, 11 receive. A legal-size request with req_addr[1:0]≠0 or an index of 12 or more raises rsp_err_map and changes nothing.
- R4: A write to index 8 ORs req_wdata[IER_W-1:0] into the mask. A write to index 9 clears every mask bit written as one. A read of either index returns the mask.
- R5: A write to line status clears only the stored bits at positions 1 (overrun), 2 (parity), 3 (framing), 4 (break) and 7 (transmit-finished) that are written as one. Every other bit ignores the write, and bits 15:8 read zero.
- R6: line_err_set bits 0..4 set line-status bits 1, 2, 3, 4 and 7. cts_change sets modem-status bit 0, which a written one clears. If a set and a clear hit the same bit in one cycle, the set wins. Modem-status bits 15:1 read zero.
- R7: A read of index 11 returns {8'h00, rx_data} sampled at the request edge and pulses rx_pop for one cycle. A write to index 11 changes nothing and pulses no strobe.
- R8: A write to index 10 stores req_wdata[7:0] on tx_data and pulses tx_load. It also pulses tx_event in the same cycle when mask bit 1 is set. A read of index 10 returns the stored byte.
- R9: A read of line status returns rx_ready in bit 0, tx_hold_empty in bit 5 and tx_idle in bit 6, as sampled at the request edge.
- R10: Indices 0, 1, 2, 3, 4 and 7 are plain 16-bit read/write registers, and the divisor and control values drive their outputs.
- R11: rsp_valid follows every request by exactly one cycle. rsp_rdata is zero for writes and for errored requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Access size code, 01 = 16 bits |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 16 | Read data |
| rsp_err_size | output | 1 | Illegal access size |
| rsp_err_map | output | 1 | Unmapped or misaligned offset |
| rx_ready | input | 1 | Receiver holds a byte |
| rx_data | input | 8 | Byte at the receiver head |
| rx_pop | output | 1 | Consume the receiver head |
| tx_hold_empty | input | 1 | Transmit holding stage empty |
| tx_idle | input | 1 | Transmitter fully idle |
| tx_load | output | 1 | Load tx_data into the transmitter |
| tx_data | output | 8 | Transmit byte |
| tx_event | output | 1 | Transmit event when enabled |
| line_err_set | input | 5 | Overrun, parity, framing, break, transmit-finished events |
| cts_change | input | 1 | Clear-to-send changed event |
| div_low | output | 16 | Low divisor register |
| div_high | output | 16 | High divisor register |
| gctl_q | output | 16 | Global control |
| lcr_q | output | 16 | Line control |
| mcr_q | output | 16 | Modem control |
| ier_q | output | IER_W | Interrupt-enable mask |

## Verification
The assertions assume that req_valid is never X after reset. They also assume that the error-event inputs are single-cycle pulses whose effect is observed only through status reads. The mask-clear and strobe properties also expect requests to come no more than one per cycle, which the bus contract already gives. The stimulus drives every input on the falling edge, holds each request for exactly one cycle, and raises set events in the same cycle as a clearing write on purpose, so the set-wins rule is exercised without breaking those assumptions.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
   localparam int NREG     = 12;
   localparam int DATA_W   = 16;
   localparam int IX_DLL   = 0;
   localparam int IX_DLH   = 1;
   localparam int IX_GCTL  = 2;
   localparam int IX_LCR   = 3;
   localparam int IX_MCR   = 4;
   localparam int IX_LSR   = 5;
   localparam int IX_MSR   = 6;
   localparam int IX_SCR   = 7;
   localparam int IX_IESET = 8;
   localparam int IX_IECLR = 9;
   localparam int IX_THR   = 10;
   localparam int IX_RBR   = 11;
   localparam logic [7:0] LSR_W1C = 8'h9E;
   localparam logic [1:0] SIZE_HALF = 2'b01;
   localparam int BIT_TXEV = 1;

   function automatic bit is_plain(input int ix);
      return ix == IX_DLL || ix == IX_DLH || ix == IX_GCTL ||
             ix == IX_LCR || ix == IX_MCR || ix == IX_SCR;
   endfunction

   function automatic logic [DATA_W-1:0] plain_rst(input int ix);
      return (ix == IX_DLL) ? 16'h0001 : 16'h0000;
   endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
   import uart_rb_pkg::*;
#(
   parameter int ADDR_W = 6
)(
   input  logic              req_valid,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [NREG-1:0]   hit,
   output logic              err_size,
   output logic              err_map
);
   localparam int IDX_W = ADDR_W - 2;
   logic [IDX_W-1:0] idx;
   logic             in_range;

   assign idx      = req_addr[ADDR_W-1:2];
   assign in_range = (req_addr[1:0] == 2'b00) && (int'(idx) < NREG);
   assign err_size = req_valid && (req_size != SIZE_HALF);
   assign err_map  = req_valid && !err_size && !in_range;

   for (genvar i = 0; i < NREG; i++) begin : g_hit
      assign hit[i] = req_valid && !err_size && in_range && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/uart_rb_sticky.sv
module uart_rb_sticky #(
   parameter int          W    = 8,
   parameter logic [W-1:0] MASK = '1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_ev,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (MASK[b]) begin : g_keep
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= 1'b0;
            else if (set_ev[b])
               r <= 1'b1;
            else if (clr_en && clr_bits[b])
               r <= 1'b0;
         end
         assign q[b] = r;
      end else begin : g_none
         assign q[b] = 1'b0;
      end
   end
endmodule

// File: rtl/uart_rb_mask.sv
module uart_rb_mask #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (set_en)
         q <= q | bits;
      else if (clr_en)
         q <= q & ~bits;
   end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int IER_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   output logic              rsp_valid,
   output logic [15:0]       rsp_rdata,
   output logic              rsp_err_size,
   output logic              rsp_err_map,
   input  logic              rx_ready,
   input  logic [7:0]        rx_data,
   output logic              rx_pop,
   input  logic              tx_hold_empty,
   input  logic              tx_idle,
   output logic              tx_load,
   output logic [7:0]        tx_data,
   output logic              tx_event,
   input  logic [4:0]        line_err_set,
   input  logic              cts_change,
   output logic [15:0]       div_low,
   output logic [15:0]       div_high,
   output logic [15:0]       gctl_q,
   output logic [15:0]       lcr_q,
   output logic [15:0]       mcr_q,
   output logic [IER_W-1:0]  ier_q
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("uart_regbank: ADDR_W must cover twelve word slots");
   end
   if (IER_W < 2 || IER_W > DATA_W) begin : g_bad_ier
      $error("uart_regbank: IER_W out of range");
   end

   logic [NREG-1:0] hit;
   logic            err_size, err_map;
   logic [NREG-1:0] wr_hit, rd_hit;
   logic [DATA_W-1:0] plain_q [NREG];
   logic [7:0]      lsr_st;
   logic [0:0]      msr_st;
   logic [7:0]      lsr_set;
   logic [7:0]      thr_q;
   logic [15:0]     rd_mux;

   uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_valid(req_valid), .req_size(req_size), .req_addr(req_addr),
      .hit(hit), .err_size(err_size), .err_map(err_map));

   assign wr_hit = req_write ? hit : '0;
   assign rd_hit = req_write ? '0 : hit;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (is_plain(i)) begin : g_rw
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= plain_rst(i);
            else if (wr_hit[i])
               r <= req_wdata;
         end
         assign plain_q[i] = r;
      end else begin : g_nrw
         assign plain_q[i] = '0;
      end
   end

   assign div_low  = plain_q[IX_DLL];
   assign div_high = plain_q[IX_DLH];
   assign gctl_q   = plain_q[IX_GCTL];
   assign lcr_q    = plain_q[IX_LCR];
   assign mcr_q    = plain_q[IX_MCR];

   assign lsr_set = {line_err_set[4], 2'b00, line_err_set[3:0], 1'b0};

   uart_rb_sticky #(.W(8), .MASK(LSR_W1C)) u_lsr (
      .clk(clk), .rst_n(rst_n), .set_ev(lsr_set), .clr_en(wr_hit[IX_LSR]),
      .clr_bits(req_wdata[7:0]), .q(lsr_st));

   uart_rb_sticky #(.W(1), .MASK(1'b1)) u_msr (
      .clk(clk), .rst_n(rst_n), .set_ev(cts_change), .clr_en(wr_hit[IX_MSR]),
      .clr_bits(req_wdata[0]), .q(msr_st));

   uart_rb_mask #(.W(IER_W)) u_ier (
      .clk(clk), .rst_n(rst_n), .set_en(wr_hit[IX_IESET]),
      .clr_en(wr_hit[IX_IECLR]), .bits(req_wdata[IER_W-1:0]), .q(ier_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thr_q <= 8'h00;
      else if (wr_hit[IX_THR])
         thr_q <= req_wdata[7:0];
   end
   assign tx_data = thr_q;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_hit[i]) begin
            if (is_plain(i))
               rd_mux = plain_q[i];
            else if (i == IX_LSR)
               rd_mux = {8'h00, lsr_st[7], tx_idle, tx_hold_empty,
                         lsr_st[4:1], rx_ready};
            else if (i == IX_MSR)
               rd_mux = {15'h0000, msr_st[0]};
            else if (i == IX_IESET || i == IX_IECLR)
               rd_mux = DATA_W'(ier_q);
            else if (i == IX_THR)
               rd_mux = {8'h00, thr_q};
            else if (i == IX_RBR)
               rd_mux = {8'h00, rx_data};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         rsp_err_size <= 1'b0;
         rsp_err_map  <= 1'b0;
         rx_pop       <= 1'b0;
         tx_load      <= 1'b0;
         tx_event     <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_rdata    <= rd_mux;
         rsp_err_size <= err_size;
         rsp_err_map  <= err_map;
         rx_pop       <= rd_hit[IX_RBR];
         tx_load      <= wr_hit[IX_THR];
         tx_event     <= wr_hit[IX_THR] && ier_q[BIT_TXEV];
      end
   end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
   parameter int ADDR_W = 6,
   parameter int IER_W  = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic [15:0]       req_wdata,
   input logic              rsp_valid,
   input logic [15:0]       rsp_rdata,
   input logic              rsp_err_size,
   input logic              rsp_err_map,
   input logic              rx_ready,
   input logic [7:0]        rx_data,
   input logic              rx_pop,
   input logic              tx_hold_empty,
   input logic              tx_idle,
   input logic              tx_load,
   input logic              tx_event,
   input logic [IER_W-1:0]  ier_q
);
   logic good;
   assign good = req_valid && req_size == 2'b01 && req_addr[1:0] == 2'b00;

   p_size_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 2'b01) |=> (rsp_err_size && !rsp_err_map && !tx_load && !rx_pop));

   p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (good && req_write && req_addr[ADDR_W-1:2] == 9) |=>
         ((ier_q & $past(req_wdata[IER_W-1:0])) == '0));

   p_rbr_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> (rsp_valid && rsp_rdata == {8'h00, $past(rx_data)}));

   p_tx_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_event |-> (tx_load && $past(ier_q[1])));

   p_lsr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (good && !req_write && req_addr[ADDR_W-1:2] == 5) |=>
         (rsp_rdata[0] == $past(rx_ready) && rsp_rdata[5] == $past(tx_hold_empty) &&
          rsp_rdata[6] == $past(tx_idle) && rsp_rdata[15:8] == 8'h00));

   p_resp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .IER_W(IER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err_size(rsp_err_size),
   .rsp_err_map(rsp_err_map), .rx_ready(rx_ready), .rx_data(rx_data),
   .rx_pop(rx_pop), .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle),
   .tx_load(tx_load), .tx_event(tx_event), .ier_q(ier_q));

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_size = 2'b01;
   logic [5:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic rx_ready = 1'b0, tx_hold_empty = 1'b1, tx_idle = 1'b1, cts_change = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic [4:0] line_err_set = '0;
   logic rsp_valid, rsp_err_size, rsp_err_map, rx_pop, tx_load, tx_event;
   logic [15:0] rsp_rdata, div_low, div_high, gctl_q, lcr_q, mcr_q;
   logic [7:0] tx_data, ier_q;

   int total = 0, bad = 0;

   always #2 clk = ~clk;

   uart_regbank u0 (.*);

   // behavioural reference state
   logic [15:0] m_plain [8];
   logic [7:0]  m_lsr, m_ier, m_thr;
   logic        m_scts;
   logic        e_valid, e_esz, e_emap, e_pop, e_load, e_evt;
   logic [15:0] e_rdata;
   string       e_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_plain[k]) m_plain[k] = 16'h0;
         m_plain[0] = 16'h0001;
         m_lsr = 0; m_ier = 0; m_thr = 0; m_scts = 0;
         e_valid = 0; e_esz = 0; e_emap = 0; e_pop = 0; e_load = 0; e_evt = 0;
         e_rdata = 0; e_tag = "R1";
      end else begin
         int ix;
         e_valid = req_valid; e_esz = 0; e_emap = 0; e_pop = 0; e_load = 0;
         e_evt = 0; e_rdata = 0; e_tag = "R11";
         ix = int'(req_addr) / 4;
         if (req_valid) begin
            if (req_size != 2'b01) begin e_esz = 1; e_tag = "R2"; end
            else if (req_addr[1:0] != 0 || ix >= 12) begin e_emap = 1; e_tag = "R3"; end
            else if (req_write) begin
               case (ix)
                  0,1,2,3,4,7: begin m_plain[ix] = req_wdata; e_tag = "R10"; end
                  5: begin m_lsr = m_lsr & ~(req_wdata[7:0] & 8'h9E); e_tag = "R5"; end
                  6: begin if (req_wdata[0]) m_scts = 0; e_tag = "R6"; end
                  8: begin m_ier = m_ier | req_wdata[7:0]; e_tag = "R4"; end
                  9: begin m_ier = m_ier & ~req_wdata[7:0]; e_tag = "R4"; end
                  10: begin m_thr = req_wdata[7:0]; e_load = 1; e_evt = m_ier[1]; e_tag = "R8"; end
                  default: e_tag = "R7";
               endcase
            end else begin
               case (ix)
                  0,1,2,3,4,7: begin e_rdata = m_plain[ix]; e_tag = "R10"; end
                  5: begin
                     e_rdata = {8'h00, m_lsr[7], tx_idle, tx_hold_empty, m_lsr[4:1], rx_ready};
                     e_tag = "R9";
                  end
                  6: begin e_rdata = {15'h0, m_scts}; e_tag = "R6"; end
                  8,9: begin e_rdata = {8'h00, m_ier}; e_tag = "R4"; end
                  10: begin e_rdata = {8'h00, m_thr}; e_tag = "R8"; end
                  default: begin e_rdata = {8'h00, rx_data}; e_pop = 1; e_tag = "R7"; end
               endcase
            end
         end
         m_lsr = m_lsr | {line_err_set[4], 2'b00, line_err_set[3:0], 1'b0};
         if (cts_change) m_scts = 1;
      end
   end

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      chk(e_tag, "rsp_valid", 16'(rsp_valid), 16'(e_valid));
      chk(e_tag, "rsp_rdata", rsp_rdata, e_rdata);
      chk(e_tag, "err_size", 16'(rsp_err_size), 16'(e_esz));
      chk(e_tag, "err_map", 16'(rsp_err_map), 16'(e_emap));
      chk(e_tag, "rx_pop", 16'(rx_pop), 16'(e_pop));
      chk(e_tag, "tx_load", 16'(tx_load), 16'(e_load));
      chk(e_tag, "tx_event", 16'(tx_event), 16'(e_evt));
      chk(e_tag, "tx_data", 16'(tx_data), 16'(m_thr));
      chk("R10", "div_low", div_low, m_plain[0]);
      chk("R10", "div_high", div_high, m_plain[1]);
      chk("R10", "gctl", gctl_q, m_plain[2]);
      chk("R10", "lcr", lcr_q, m_plain[3]);
      chk("R10", "mcr", mcr_q, m_plain[4]);
      chk("R4", "ier", 16'(ier_q), 16'(m_ier));
   end

   task automatic acc(input bit w, input logic [1:0] sz, input logic [5:0] a, input logic [15:0] d);
      req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; line_err_set = 0; cts_change = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values visible directly
      chk("R1", "div_low reset", div_low, 16'h0001);
      chk("R1", "ier reset", 16'(ier_q), 16'h0000);
      acc(0, 2'b01, 6'd20, 0); @(negedge clk);
      chk("R1", "lsr reset read", rsp_rdata, 16'h0000); // response already gone
      acc(0, 2'b01, 6'd20, 0);
      chk("R1", "lsr reset value", rsp_rdata, 16'h0060);
      // R10 plain registers
      for (int i = 0; i < 8; i++) if (i != 5 && i != 6) acc(1, 2'b01, 6'(i*4), 16'hA500 + 16'(i*17));
      for (int i = 0; i < 8; i++) acc(0, 2'b01, 6'(i*4), 0);
      // R2 bad sizes, incl. bad offset too
      acc(1, 2'b00, 6'd0, 16'h1234);
      acc(1, 2'b10, 6'd2, 16'h1234);
      acc(0, 2'b11, 6'd60, 0);
      // R3 misaligned and unmapped
      acc(1, 2'b01, 6'd1, 16'hFFFF);
      acc(1, 2'b01, 6'd48, 16'hFFFF);
      acc(0, 2'b01, 6'd60, 0);
      // R4 mask set/clear
      acc(1, 2'b01, 6'd32, 16'hFF0C);
      acc(1, 2'b01, 6'd32, 16'h0003);
      acc(1, 2'b01, 6'd36, 16'h0005);
      acc(0, 2'b01, 6'd32, 0);
      acc(0, 2'b01, 6'd36, 0);
      // R8 THR with event enabled, then disabled
      acc(1, 2'b01, 6'd40, 16'h7E5A);
      acc(0, 2'b01, 6'd40, 0);
      acc(1, 2'b01, 6'd36, 16'h0002);
      acc(1, 2'b01, 6'd40, 16'h00C3);
      // R5/R6 sticky flags
      line_err_set = 5'b11111; cts_change = 1; @(negedge clk);
      line_err_set = 0; cts_change = 0;
      acc(0, 2'b01, 6'd20, 0);
      acc(1, 2'b01, 6'd20, 16'hFF06);
      acc(0, 2'b01, 6'd20, 0);
      line_err_set = 5'b00100;
      acc(1, 2'b01, 6'd20, 16'h0098);
      acc(0, 2'b01, 6'd20, 0);
      acc(0, 2'b01, 6'd24, 0);
      cts_change = 1;
      acc(1, 2'b01, 6'd24, 16'hFFFF);
      acc(0, 2'b01, 6'd24, 0);
      acc(1, 2'b01, 6'd24, 16'h0001);
      acc(0, 2'b01, 6'd24, 0);
      // R9 live status patterns
      rx_ready = 1; tx_hold_empty = 0; tx_idle = 0;
      acc(0, 2'b01, 6'd20, 0);
      rx_ready = 0; tx_hold_empty = 1; tx_idle = 0;
      acc(0, 2'b01, 6'd20, 0);
      // R7 receive reads and ignored write
      rx_data = 8'h3C; acc(0, 2'b01, 6'd44, 0);
      rx_data = 8'hF1; acc(0, 2'b01, 6'd44, 0);
      acc(1, 2'b01, 6'd44, 16'hBEEF);
      acc(0, 2'b01, 6'd40, 0);
      // back-to-back mixed traffic
      for (int i = 0; i < 40; i++) begin
         rx_data = 8'(i * 7);
         rx_ready = i[0];
         acc(i[1], 2'b01, 6'((i % 13) * 4), 16'(i * 16'h0931));
      end
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule